// File: doc/BRIEF.md
# Bidirectional Universal Bus Register-Transceiver

This block passes a 17-bit word in two directions between an A-side bus and a B-side bus. Each direction owns one storage stage. A latch enable, a clock enable and a clock strobe drive that stage, and the way they are driven picks one of four modes:

- **Transparent:** the output follows the input while latch enable is high.
- **Latched:** the input is captured when latch enable falls.
- **Clocked:** the input is loaded on a rising strobe while clock enable is low.
- **Clock-enabled:** clock enable high inhibits loading.

An active-low output enable gates whether each side is driven. Data is never inverted.

The whole block runs on one fast system clock. Latch enable, clock enable, strobe and input data pass through matched synchronizer pipelines, so a control edge and the data beside it are seen in the same cycle. Every three-state bus appears as a data output plus a separate drive-enable output.

A side path copies the A-to-B strobe onto a B-side clock output. It then loops that value back onto an A-side clock input. Each leg is driven only while the matching output enable is low.

Driving both output enables low at once is a discouraged condition. A sticky flag records it until reset.

Top module: `bus_regxcvr`

## Requirements
- R1: While a direction's latch enable is high, its data output equals its data input, bit for bit and without inversion, three system cycles after the input is applied. Clock enable and strobe have no effect in this mode.
- R2: On a high-to-low change of latch enable, the stage captures the input present together with that change. It keeps that value afterwards.
- R3: With latch enable low and clock enable low, a low-to-high change of the strobe loads the input into the stage.
- R4: With latch enable low and clock enable high, strobe edges leave the stored value unchanged.
- R5: With latch enable low and the strobe held at a steady level, changes on the data input leave the stored value unchanged.
- R6: The B-to-A direction follows R1 to R5 with its own four controls. Activity on one direction does not alter the other direction's stored value.
- R7: A data drive-enable output is 1 exactly one system cycle after its active-low output enable is sampled 0. It is 0 one cycle after that enable is sampled 1.
- R8: The B-side clock output equals the A-to-B strobe delayed by three system cycles. Its drive enable follows the A-to-B output enable as in R7.
- R9: The A-side clock input equals the B-side clock output delayed by one system cycle. Its drive enable follows the B-to-A output enable as in R7.
- R10: The conflict flag goes to 1 one cycle after both output enables are sampled 0 together. It stays 1 until reset.
- R11: Synchronous reset clears both stored words, all drive enables, both clock outputs and the conflict flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data_i | input | 17 | A-side input word, flowing toward B |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_ce_n_i | input | 1 | A-to-B clock enable, active low |
| ab_stb_i | input | 1 | A-to-B clock strobe |
| ab_oe_n_i | input | 1 | A-to-B output enable, active low |
| b_data_i | input | 17 | B-side input word, flowing toward A |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_ce_n_i | input | 1 | B-to-A clock enable, active low |
| ba_stb_i | input | 1 | B-to-A clock strobe |
| ba_oe_n_i | input | 1 | B-to-A output enable, active low |
| b_data_o | output | 17 | B-side output word |
| b_drv_o | output | 1 | B-side data drive enable |
| a_data_o | output | 17 | A-side output word |
| a_drv_o | output | 1 | A-side data drive enable |
| clk_b_o | output | 1 | Forwarded strobe on the B side |
| clk_b_drv_o | output | 1 | Drive enable of clk_b_o |
| clk_a_o | output | 1 | Looped-back clock on the A side |
| clk_a_drv_o | output | 1 | Drive enable of clk_a_o |
| both_drv_seen_o | output | 1 | Sticky flag: both output enables were low together |

## Verification
Each direction is swept with walking-one words plus dense mixed words. Every word is applied under all eight combinations of latch enable, clock enable and strobe pulse.

A reference model in the bench updates the expected word only when latch enable is high, when it has just fallen, or when a strobe pulse meets an active clock enable. This separates transparent following, capture on the falling edge, clocked loading, clock inhibit and plain hold. The walking ones expose any swapped or inverted bit.

The clock loop is stepped cycle by cycle to pin its three-cycle and four-cycle latencies. The output enables are toggled one at a time and then together to separate the drive gating from the sticky conflict flag.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;
  typedef struct packed {
    logic le;
    logic ce_n;
    logic stb;
  } dir_ctl_t;

  localparam int CTL_W = $bits(dir_ctl_t);
endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xfer_stage.sv
module xfer_stage
  import regxcvr_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_s,
  input  dir_ctl_t     ctl_s,
  input  logic         oe_n,
  output logic [W-1:0] q,
  output logic         drv,
  output logic         le_prev,
  output logic         stb_prev
);
  logic le_fall;
  logic stb_rise_load;

  // Edges are found by comparing the current synchronized sample with the previous one.
  assign le_fall       = le_prev & ~ctl_s.le;
  assign stb_rise_load = ctl_s.stb & ~stb_prev & ~ctl_s.ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      drv      <= 1'b0;
      le_prev  <= 1'b0;
      stb_prev <= 1'b0;
    end else begin
      le_prev  <= ctl_s.le;
      stb_prev <= ctl_s.stb;
      drv      <= ~oe_n;
      if (ctl_s.le || le_fall || stb_rise_load) q <= d_s;
    end
  end
endmodule

// File: rtl/dir_path.sv
module dir_path
  import regxcvr_pkg::*;
#(
  parameter int W      = 17,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  input  dir_ctl_t     ctl_i,
  input  logic         oe_n_i,
  output logic [W-1:0] q_o,
  output logic         drv_o,
  output logic [W-1:0] d_s_o,
  output dir_ctl_t     ctl_s_o,
  output logic         le_prev_o,
  output logic         stb_prev_o
);
  logic [CTL_W-1:0] ctl_bits;

  sync_pipe #(.W(W), .STAGES(STAGES)) u_dsync (
    .clk (clk),
    .rst (rst),
    .d   (d_i),
    .q   (d_s_o)
  );

  sync_pipe #(.W(CTL_W), .STAGES(STAGES)) u_csync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_i),
    .q   (ctl_bits)
  );

  assign ctl_s_o = dir_ctl_t'(ctl_bits);

  xfer_stage #(.W(W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .d_s      (d_s_o),
    .ctl_s    (ctl_s_o),
    .oe_n     (oe_n_i),
    .q        (q_o),
    .drv      (drv_o),
    .le_prev  (le_prev_o),
    .stb_prev (stb_prev_o)
  );
endmodule

// File: rtl/clk_loop.sv
module clk_loop (
  input  logic clk,
  input  logic rst,
  input  logic stb_s,
  input  logic ab_oe_n,
  input  logic ba_oe_n,
  output logic clk_b,
  output logic clk_b_drv,
  output logic clk_a,
  output logic clk_a_drv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_b     <= 1'b0;
      clk_b_drv <= 1'b0;
      clk_a     <= 1'b0;
      clk_a_drv <= 1'b0;
    end else begin
      clk_b     <= stb_s;
      clk_b_drv <= ~ab_oe_n;
      clk_a     <= clk_b;
      clk_a_drv <= ~ba_oe_n;
    end
  end
endmodule

// File: rtl/bus_regxcvr.sv
module bus_regxcvr
  import regxcvr_pkg::*;
#(
  parameter int WIDTH       = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_data_i,
  input  logic             ab_le_i,
  input  logic             ab_ce_n_i,
  input  logic             ab_stb_i,
  input  logic             ab_oe_n_i,
  input  logic [WIDTH-1:0] b_data_i,
  input  logic             ba_le_i,
  input  logic             ba_ce_n_i,
  input  logic             ba_stb_i,
  input  logic             ba_oe_n_i,
  output logic [WIDTH-1:0] b_data_o,
  output logic             b_drv_o,
  output logic [WIDTH-1:0] a_data_o,
  output logic             a_drv_o,
  output logic             clk_b_o,
  output logic             clk_b_drv_o,
  output logic             clk_a_o,
  output logic             clk_a_drv_o,
  output logic             both_drv_seen_o
);
  dir_ctl_t         ab_ctl, ba_ctl, ab_ctl_s, ba_ctl_s;
  logic [WIDTH-1:0] ab_d_s, ba_d_s;
  logic             ab_le_prev, ab_stb_prev, ba_le_prev, ba_stb_prev;
  logic             flag_q;

  assign ab_ctl = '{le: ab_le_i, ce_n: ab_ce_n_i, stb: ab_stb_i};
  assign ba_ctl = '{le: ba_le_i, ce_n: ba_ce_n_i, stb: ba_stb_i};

  dir_path #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_ab (
    .clk        (clk),
    .rst        (rst),
    .d_i        (a_data_i),
    .ctl_i      (ab_ctl),
    .oe_n_i     (ab_oe_n_i),
    .q_o        (b_data_o),
    .drv_o      (b_drv_o),
    .d_s_o      (ab_d_s),
    .ctl_s_o    (ab_ctl_s),
    .le_prev_o  (ab_le_prev),
    .stb_prev_o (ab_stb_prev)
  );

  dir_path #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_ba (
    .clk        (clk),
    .rst        (rst),
    .d_i        (b_data_i),
    .ctl_i      (ba_ctl),
    .oe_n_i     (ba_oe_n_i),
    .q_o        (a_data_o),
    .drv_o      (a_drv_o),
    .d_s_o      (ba_d_s),
    .ctl_s_o    (ba_ctl_s),
    .le_prev_o  (ba_le_prev),
    .stb_prev_o (ba_stb_prev)
  );

  clk_loop u_clk (
    .clk       (clk),
    .rst       (rst),
    .stb_s     (ab_ctl_s.stb),
    .ab_oe_n   (ab_oe_n_i),
    .ba_oe_n   (ba_oe_n_i),
    .clk_b     (clk_b_o),
    .clk_b_drv (clk_b_drv_o),
    .clk_a     (clk_a_o),
    .clk_a_drv (clk_a_drv_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                           flag_q <= 1'b0;
    else if (!ab_oe_n_i && !ba_oe_n_i) flag_q <= 1'b1;
  end

  assign both_drv_seen_o = flag_q;
endmodule

// File: rtl/regxcvr_checker.sv
module regxcvr_checker #(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst,
  input logic         ab_le_s,
  input logic         ab_le_p,
  input logic         ab_ce_n_s,
  input logic         ab_stb_s,
  input logic         ab_stb_p,
  input logic [W-1:0] ab_d_s,
  input logic         ba_le_s,
  input logic [W-1:0] ba_d_s,
  input logic [W-1:0] b_data_o,
  input logic [W-1:0] a_data_o,
  input logic         ab_oe_n_i,
  input logic         b_drv_o,
  input logic         clk_b_o,
  input logic         clk_a_o,
  input logic         flag
);
  assert_transparent_R1: assert property (@(posedge clk) disable iff (rst)
    ab_le_s |=> (b_data_o == $past(ab_d_s)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ab_le_s && !ab_le_p && !(ab_stb_s && !ab_stb_p && !ab_ce_n_s)) |=> $stable(b_data_o));

  assert_ba_transparent_R6: assert property (@(posedge clk) disable iff (rst)
    ba_le_s |=> (a_data_o == $past(ba_d_s)));

  assert_drive_on_R7: assert property (@(posedge clk) disable iff (rst)
    !ab_oe_n_i |=> b_drv_o);

  assert_drive_off_R7: assert property (@(posedge clk) disable iff (rst)
    ab_oe_n_i |=> !b_drv_o);

  assert_clk_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_b_o == $past(ab_stb_s)));

  assert_clk_loop_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_a_o == $past(clk_b_o)));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);
endmodule

bind bus_regxcvr regxcvr_checker #(.W(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ab_le_s   (ab_ctl_s.le),
  .ab_le_p   (ab_le_prev),
  .ab_ce_n_s (ab_ctl_s.ce_n),
  .ab_stb_s  (ab_ctl_s.stb),
  .ab_stb_p  (ab_stb_prev),
  .ab_d_s    (ab_d_s),
  .ba_le_s   (ba_ctl_s.le),
  .ba_d_s    (ba_d_s),
  .b_data_o  (b_data_o),
  .a_data_o  (a_data_o),
  .ab_oe_n_i (ab_oe_n_i),
  .b_drv_o   (b_drv_o),
  .clk_b_o   (clk_b_o),
  .clk_a_o   (clk_a_o),
  .flag      (both_drv_seen_o)
);

// File: tb/tb_bus_regxcvr.sv
module tb_bus_regxcvr;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 17;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_data_i = '0, b_data_i = '0;
  logic ab_le_i = 0, ab_ce_n_i = 1, ab_stb_i = 0, ab_oe_n_i = 1;
  logic ba_le_i = 0, ba_ce_n_i = 1, ba_stb_i = 0, ba_oe_n_i = 1;
  logic [W-1:0] b_data_o, a_data_o;
  logic b_drv_o, a_drv_o, clk_b_o, clk_b_drv_o, clk_a_o, clk_a_drv_o, both_drv_seen_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_b = '0, exp_a = '0;
  logic prev_ab_le = 0, prev_ba_le = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_regxcvr #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst),
    .a_data_i(a_data_i), .ab_le_i(ab_le_i), .ab_ce_n_i(ab_ce_n_i), .ab_stb_i(ab_stb_i), .ab_oe_n_i(ab_oe_n_i),
    .b_data_i(b_data_i), .ba_le_i(ba_le_i), .ba_ce_n_i(ba_ce_n_i), .ba_stb_i(ba_stb_i), .ba_oe_n_i(ba_oe_n_i),
    .b_data_o(b_data_o), .b_drv_o(b_drv_o), .a_data_o(a_data_o), .a_drv_o(a_drv_o),
    .clk_b_o(clk_b_o), .clk_b_drv_o(clk_b_drv_o), .clk_a_o(clk_a_o), .clk_a_drv_o(clk_a_drv_o),
    .both_drv_seen_o(both_drv_seen_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic le, input logic prev_le, input logic ce_n, input logic pulse);
    if (le)                 return "R1";
    else if (prev_le)       return "R2";
    else if (pulse && !ce_n) return "R3";
    else if (pulse)         return "R4";
    else                    return "R5";
  endfunction

  task automatic ab_op(input logic le, input logic ce_n, input logic pulse, input logic [W-1:0] d);
    string t;
    a_data_i = d; ab_le_i = le; ab_ce_n_i = ce_n;
    tick(5);
    if (pulse) begin
      ab_stb_i = 1; tick(5);
      ab_stb_i = 0; tick(5);
    end
    t = tag(le, prev_ab_le, ce_n, pulse);
    if (le || prev_ab_le || (pulse && !ce_n)) exp_b = d;
    prev_ab_le = le;
    chk(t, 32'(b_data_o), 32'(exp_b));
    chk("R6 isolation of B-to-A", 32'(a_data_o), 32'(exp_a));
  endtask

  task automatic ba_op(input logic le, input logic ce_n, input logic pulse, input logic [W-1:0] d);
    b_data_i = d; ba_le_i = le; ba_ce_n_i = ce_n;
    tick(5);
    if (pulse) begin
      ba_stb_i = 1; tick(5);
      ba_stb_i = 0; tick(5);
    end
    if (le || prev_ba_le || (pulse && !ce_n)) exp_a = d;
    prev_ba_le = le;
    chk("R6 B-to-A mode", 32'(a_data_o), 32'(exp_a));
    chk("R6 isolation of A-to-B", 32'(b_data_o), 32'(exp_b));
  endtask

  initial begin
    tick(4);
    // R11: reset state
    chk("R11 b_data", 32'(b_data_o), 0);
    chk("R11 a_data", 32'(a_data_o), 0);
    chk("R11 drives", {28'd0, b_drv_o, a_drv_o, clk_b_drv_o, clk_a_drv_o}, 0);
    chk("R11 clocks", {30'd0, clk_b_o, clk_a_o}, 0);
    chk("R11 flag", 32'(both_drv_seen_o), 0);
    rst = 0;
    tick(2);

    // R7: A-to-B drive enable one cycle after the enable goes low
    ab_oe_n_i = 0;
    tick(1);
    chk("R7 b_drv on", 32'(b_drv_o), 1);
    chk("R8 clk_b_drv on", 32'(clk_b_drv_o), 1);
    chk("R7 a_drv stays off", 32'(a_drv_o), 0);
    chk("R10 flag clear with one enable", 32'(both_drv_seen_o), 0);

    // A-to-B sweep: walking ones plus mixed words, all eight control combinations
    for (int p = 0; p < W + 2; p++) begin
      logic [W-1:0] base;
      if (p < W)       base = MASK & (W'(1) << p);
      else if (p == W) base = MASK;
      else             base = MASK & W'(32'h0AAAA);
      for (int m = 0; m < 8; m++) begin
        ab_op(m[2], m[1], m[0], (base ^ W'(m * 32'h1111)) & MASK);
      end
    end

    // B-to-A sweep with its own controls
    ab_oe_n_i = 1; ba_oe_n_i = 0;
    tick(1);
    chk("R7 a_drv on", 32'(a_drv_o), 1);
    chk("R7 b_drv off", 32'(b_drv_o), 0);
    chk("R9 clk_a_drv on", 32'(clk_a_drv_o), 1);
    for (int p = 0; p < W; p++) begin
      for (int m = 0; m < 8; m++) begin
        ba_op(m[2], m[1], m[0], (MASK & (W'(1) << p)) ^ W'(m));
      end
    end

    // R8/R9: clock loop latency, with loads inhibited (R4)
    ab_le_i = 0; ab_ce_n_i = 1;
    tick(5);
    ab_stb_i = 1;
    tick(2);
    chk("R8 clk_b not yet", 32'(clk_b_o), 0);
    tick(1);
    chk("R8 clk_b after 3", 32'(clk_b_o), 1);
    chk("R9 clk_a not yet", 32'(clk_a_o), 0);
    tick(1);
    chk("R9 clk_a after 4", 32'(clk_a_o), 1);
    ab_stb_i = 0;
    tick(3);
    chk("R8 clk_b falls", 32'(clk_b_o), 0);
    tick(1);
    chk("R9 clk_a falls", 32'(clk_a_o), 0);
    chk("R4 strobe inhibited", 32'(b_data_o), 32'(exp_b));
    chk("R8 clk_b_drv off", 32'(clk_b_drv_o), 0);

    // R10: conflict flag is sticky
    ab_oe_n_i = 0;
    tick(1);
    chk("R10 flag set", 32'(both_drv_seen_o), 1);
    ab_oe_n_i = 1; ba_oe_n_i = 1;
    tick(3);
    chk("R10 flag sticky", 32'(both_drv_seen_o), 1);
    rst = 1;
    tick(1);
    chk("R11 flag cleared", 32'(both_drv_seen_o), 0);
    chk("R11 b_data cleared", 32'(b_data_o), 0);
    rst = 0;
    tick(1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule